// File: doc/BRIEF.md
# Two-Stage SCL Rate Divider

This block paces the serial clock of an I2C master. Two programmable prescale stages run in series from the peripheral clock. Together they issue one step enable every (A+1)·(B+1) clock cycles. A phase counter consumes those steps and splits each SCL period into 22 equal steps: 11 with SCL high, then 11 with SCL low. The resulting SCL rate is the clock rate divided by 22·(A+1)·(B+1), so it can never exceed one twenty-second of the input clock. Software works out A and B; this block only applies them.

The bit-level sequencer raises `run` to start the clock and drops it to stop. While `run` is low, every counter sits at zero and SCL is held high. On each idle cycle the two divider fields are copied into internal registers. This means edits made during a transfer have no effect until the next idle period. A slave can stretch the clock: while the block is in its high phase and the sampled bus line `scl_in` reads low, the whole divider freezes until the line is released.

Top module: `scl_rate_div`

## Requirements
- R1: While `run` is low, and during reset, `scl_out` is 1 and `tick` is 0.
- R2: While running without stretching, `tick` pulses for one cycle every (A+1)·(B+1) clock cycles. A is `div_a` (2 bits, ratio 1 to 4) and B is `div_b` (6 bits, ratio 1 to 64). The first pulse comes (A+1)·(B+1) cycles after `run` rises.
- R3: One SCL period is 22 ticks. `scl_out` is 1 from the cycle `run` rises until the 11th tick. It is then 0 until the 22nd tick, after which the pattern repeats.
- R4: With A=0 and B=0, `tick` is high on every running cycle and the SCL period is 22 clock cycles, the fastest possible.
- R5: If `scl_in` is 0 while running in the high phase, `tick` is 0 and both the prescaler and the phase position are frozen. Counting resumes from the same point once `scl_in` returns to 1.
- R6: During the low phase, `scl_in` has no effect on `tick` or `scl_out`.
- R7: The divider fields are captured on every clock edge where `run` is low. Changes to `div_a` or `div_b` while `run` is high do not alter the tick spacing.
- R8: Dropping `run` in the middle of a period returns SCL high at once. A later restart begins a fresh high phase with a full prescale interval.
- R9: With A=3 and B=63, ticks are 256 cycles apart and one SCL period is 5632 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Run enable from the sequencer |
| div_a | input | 2 | First-stage divide value A (ratio A+1) |
| div_b | input | 6 | Second-stage divide value B (ratio B+1) |
| scl_in | input | 1 | Synchronised SCL level sampled from the bus |
| tick | output | 1 | One-cycle step enable, 22 per SCL period |
| scl_out | output | 1 | SCL level requested toward the bit engine |

## Verification
The divider is run with A=B=0, with a mixed setting A=1, B=2, and with the largest setting A=3, B=63. Together these separate a single-stage count from a correct cascaded product and expose any wrap error at the top of either stage. Pulling `scl_in` low in the high phase and then in the low phase shows whether stretching freezes only where it should. Editing the fields mid-run and dropping `run` mid-period shows whether configuration capture and the abort path clear or retain the right state.

// File: rtl/scl_div_pkg.sv
package scl_div_pkg;
  localparam int unsigned SCL_STEPS = 22;
  localparam int unsigned SCL_HALF  = SCL_STEPS / 2;
  localparam int unsigned STEP_W    = $clog2(SCL_STEPS);
endpackage

// File: rtl/scl_prescale_stage.sv
module scl_prescale_stage #(
  parameter int unsigned W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic         hold,
  input  logic [W-1:0] limit,
  output logic         wrap
);
  logic [W-1:0] cnt_q, cnt_d;

  assign wrap = en && (cnt_q == limit);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)              cnt_d = '0;
    else if (en && !hold) cnt_d = wrap ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assert_count_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= limit);
  assert_freeze_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(hold && !clr) |-> cnt_q == $past(cnt_q));
  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clr) |-> cnt_q == '0);
endmodule

// File: rtl/scl_phase_seq.sv
module scl_phase_seq
  import scl_div_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic step,
  input  logic scl_in,
  output logic stretch,
  output logic scl_out
);
  localparam logic [STEP_W-1:0] LAST = STEP_W'(SCL_STEPS - 1);
  localparam logic [STEP_W-1:0] HALF = STEP_W'(SCL_HALF);

  logic [STEP_W-1:0] ph_q, ph_d;
  logic              high_phase;

  assign high_phase = (ph_q < HALF);
  assign stretch    = run && high_phase && !scl_in;
  assign scl_out    = !run || high_phase;

  always_comb begin
    ph_d = ph_q;
    if (!run)      ph_d = '0;
    else if (step) ph_d = (ph_q == LAST) ? '0 : ph_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= '0;
    else        ph_q <= ph_d;
  end

  assert_phase_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ph_q <= LAST);
  assert_phase_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(run && step) |-> ph_q == (($past(ph_q) == LAST) ? '0 : $past(ph_q) + 1'b1));
  assert_phase_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(run && stretch) |-> ph_q == $past(ph_q));
  assert_phase_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!run) |-> ph_q == '0);
endmodule

// File: rtl/scl_rate_div.sv
module scl_rate_div #(
  parameter int unsigned A_W = 2,
  parameter int unsigned B_W = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run,
  input  logic [A_W-1:0] div_a,
  input  logic [B_W-1:0] div_b,
  input  logic           scl_in,
  output logic           tick,
  output logic           scl_out
);
  logic [A_W-1:0] cfg_a_q, cfg_a_d;
  logic [B_W-1:0] cfg_b_q, cfg_b_d;
  logic           a_wrap, b_wrap, stretch;

  always_comb begin
    cfg_a_d = cfg_a_q;
    cfg_b_d = cfg_b_q;
    if (!run) begin
      cfg_a_d = div_a;
      cfg_b_d = div_b;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_a_q <= '0;
      cfg_b_q <= '0;
    end else begin
      cfg_a_q <= cfg_a_d;
      cfg_b_q <= cfg_b_d;
    end
  end

  scl_prescale_stage #(.W(A_W)) u_stage_a (
    .clk(clk), .rst_n(rst_n), .clr(!run), .en(run), .hold(stretch),
    .limit(cfg_a_q), .wrap(a_wrap));

  scl_prescale_stage #(.W(B_W)) u_stage_b (
    .clk(clk), .rst_n(rst_n), .clr(!run), .en(a_wrap), .hold(stretch),
    .limit(cfg_b_q), .wrap(b_wrap));

  assign tick = b_wrap && !stretch;

  scl_phase_seq u_phase (
    .clk(clk), .rst_n(rst_n), .run(run), .step(tick), .scl_in(scl_in),
    .stretch(stretch), .scl_out(scl_out));

  assert_cfg_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(run) |-> ($stable(cfg_a_q) && $stable(cfg_b_q)));
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (!tick && scl_out));
  assert_stretch_no_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !scl_in && scl_out) |-> !tick);
endmodule

// File: tb/scl_rate_div_bench.sv
module scl_rate_div_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       run;
  logic [1:0] div_a;
  logic [5:0] div_b;
  logic       scl_in;
  logic       tick, scl_out;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done   = 0;

  int m_acc   = 0;
  int m_phase = 0;
  int m_n     = 1;

  always #10 clk = ~clk;

  scl_rate_div u_scl_rate_div (
    .clk(clk), .rst_n(rst_n), .run(run), .div_a(div_a), .div_b(div_b),
    .scl_in(scl_in), .tick(tick), .scl_out(scl_out));

  task automatic check_bit(input string tag, input string what, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s got=%0b expected=%0b at cycle %0d", tag, what, got, exp, cycles);
    end
  endtask

  // Drive one cycle, compare against the model, then advance the model over the coming edge.
  task automatic step(input string tag, input logic r, input logic s);
    bit e_stretch, e_tick, e_scl;
    run = r; scl_in = s;
    #1;
    e_stretch = r && (m_phase < 11) && !s;
    e_tick    = r && !e_stretch && (m_acc == m_n - 1);
    e_scl     = !r || (m_phase < 11);
    check_bit(tag, "tick", tick, e_tick);
    check_bit(tag, "scl_out", scl_out, e_scl);
    if (!r) begin
      m_acc = 0; m_phase = 0;
      m_n = (int'(div_a) + 1) * (int'(div_b) + 1);
    end else if (!e_stretch) begin
      if (m_acc == m_n - 1) begin
        m_acc = 0;
        m_phase = (m_phase == 21) ? 0 : m_phase + 1;
      end else m_acc++;
    end
    @(negedge clk);
    cycles++;
  endtask

  task automatic idle(input string tag, input int n);
    for (int i = 0; i < n; i++) step(tag, 1'b0, 1'b1);
  endtask

  task automatic go(input string tag, input int n);
    for (int i = 0; i < n; i++) step(tag, 1'b1, 1'b1);
  endtask

  initial begin
    while (!done && cycles < 150000) @(negedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired at cycle %0d", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; run = 1'b0; scl_in = 1'b1; div_a = 2'd0; div_b = 6'd0;
    @(negedge clk); #1;
    check_bit("R1", "tick in reset", tick, 1'b0);
    check_bit("R1", "scl_out in reset", scl_out, 1'b1);
    @(negedge clk);
    rst_n = 1'b1;
    idle("R1", 3);

    // R4: fastest setting, two full periods
    div_a = 2'd0; div_b = 6'd0;
    idle("R4", 2);
    go("R4", 50);

    // R2 / R3: mixed setting, product 6
    idle("R2", 2);
    div_a = 2'd1; div_b = 6'd2;
    idle("R2", 2);
    go("R3", 300);

    // R5 / R6: stretching in the high phase, then pulls in the low phase
    idle("R5", 1);
    div_a = 2'd0; div_b = 6'd1;
    idle("R5", 2);
    go("R5", 5);
    for (int i = 0; i < 7; i++) step("R5", 1'b1, 1'b0);
    go("R5", 20);
    for (int i = 0; i < 10; i++) step("R6", 1'b1, 1'b0);
    go("R6", 40);

    // R7: edits while running are ignored
    idle("R7", 1);
    div_a = 2'd1; div_b = 6'd0;
    idle("R7", 2);
    go("R7", 20);
    div_a = 2'd3; div_b = 6'd5;
    go("R7", 80);

    // R8: abort mid-period and restart with the new fields
    idle("R8", 3);
    go("R8", 5);
    idle("R8", 2);
    go("R8", 60);

    // R9: largest setting, one full period plus margin
    idle("R9", 1);
    div_a = 2'd3; div_b = 6'd63;
    idle("R9", 2);
    go("R9", 5800);
    idle("R9", 2);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule